// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be kept. Each incoming identifier, presented as four bytes with a one-cycle strobe, is compared against eight programmable acceptance-code bytes. Eight mask bytes qualify the comparison bit by bit. A mask bit of 1 makes the identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.

The eight code/mask byte pairs are grouped in one of two ways. In wide mode they form two filters of four bytes, each compared against the whole identifier. In narrow mode they form four filters of two bytes, each compared against the first two identifier bytes. One cycle after the strobe, the block reports whether any filter matched and the number of the lowest matching filter.

The configuration is reached through a byte-wide register port. It can be read at any time. It can be written only while the controller reports initialization mode, meaning both the request and the acknowledge flags are high.

Result timing comes from a two-state reporter:
- ST_IDLE moves to ST_REPORT when the strobe is seen.
- ST_REPORT stays in ST_REPORT while the strobe continues.
- ST_REPORT returns to ST_IDLE when the strobe is absent.

`res_valid` is high exactly while the reporter is in ST_REPORT.

Top module: `can_acc_filter`

## Requirements
- R1: After reset, every code, mask and mode register reads 0, and `accept` and `res_valid` are 0.
- R2: For each bit, a mask bit of 1 makes the identifier bit irrelevant to the match, and a mask bit of 0 requires the identifier bit to equal the code bit.
- R3: A filter matches only when every byte it spans passes the masked compare. A single differing must-match bit rejects the filter.
- R4: Wide mode is selected by mode bit 0 = 0.
  - Filter 0 uses code bytes at 0x10–0x13 and masks at 0x14–0x17.
  - Filter 1 uses code bytes at 0x18–0x1B and masks at 0x1C–0x1F.
  - Filter byte i is compared with identifier byte i, where byte 0 is `id_word[31:24]`.
  - `hit_idx` is never above 1 in this mode.
- R5: Narrow mode is selected by mode bit 0 = 1.
  - Code bytes 0..7 are those at 0x10–0x13 followed by those at 0x18–0x1B.
  - Filter j uses code bytes 2j and 2j+1 with the matching mask bytes.
  - Each filter is compared with identifier bytes 0 and 1 only. `id_word[15:0]` is ignored.
- R6: `accept` is 1 when any active filter matches. `hit_idx` is the lowest matching filter number, or 0 when none matches.
- R7: `res_valid`, `accept` and `hit_idx` change one clock after a cycle with `id_valid` high. With no strobe, `res_valid` and `accept` go to 0 and `hit_idx` holds.
- R8: Registers are writable only while `init_req` and `init_ack` are both 1. Writes at other times leave every register unchanged. Reads return the current contents at any time.
- R9: The mode register is at 0x00 and holds only bit 0. Any other address outside the code and mask ranges reads 0 and ignores writes.
- R10: Standard 11-bit identifiers are accepted when the low three mask bits of each filter's second byte are set. The low three bits of identifier byte 1 then do not affect the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Controller initialization request flag |
| init_ack | input | 1 | Controller initialization acknowledge flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| id_valid | input | 1 | Identifier strobe |
| id_word | input | 32 | Identifier bytes, byte 0 in bits 31:24 |
| res_valid | output | 1 | Result valid, one cycle after `id_valid` |
| accept | output | 1 | Frame accepted |
| hit_idx | output | 2 | Lowest matching filter number |

## Verification
The assertions assume three things about the inputs:
- `id_valid` and `id_word` are stable across each rising edge.
- Configuration writes happen at an edge rather than mid-cycle.
- The mode can change in the same cycle as a strobe, so the wide-mode index check refers to the mode that was in force when the identifier was sampled.

The stimulus drives every input on the falling edge. It toggles `init_ack` during the random phase, so write attempts are made both inside and outside initialization mode. It also changes the mode between identifiers. Each result is therefore judged against the configuration that was live on the sampling edge.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int MODE_ADDR  = 0;
    localparam int CODE_BANK0 = 16;
    localparam int MASK_BANK0 = 20;
    localparam int CODE_BANK1 = 24;
    localparam int MASK_BANK1 = 28;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rep_state_e;

    function automatic int code_addr(input int k, input int half);
        return ((k < half) ? CODE_BANK0 : CODE_BANK1) + (k % half);
    endfunction

    function automatic int mask_addr(input int k, input int half);
        return ((k < half) ? MASK_BANK0 : MASK_BANK1) + (k % half);
    endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 8,
    parameter int N_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_open,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [N_BYTES*DATA_W-1:0] code_flat,
    output logic [N_BYTES*DATA_W-1:0] mask_flat,
    output logic                      mode16
);
    localparam int HALF = N_BYTES / 2;

    logic wr_en;
    assign wr_en = wr_open & reg_wr;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam int CA = code_addr(k, HALF);
        localparam int MA = mask_addr(k, HALF);
        logic [DATA_W-1:0] code_q;
        logic [DATA_W-1:0] mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
                mask_q <= '0;
            end else if (wr_en) begin
                if (reg_addr == ADDR_W'(CA)) code_q <= reg_wdata;
                if (reg_addr == ADDR_W'(MA)) mask_q <= reg_wdata;
            end
        end

        assign code_flat[k*DATA_W +: DATA_W] = code_q;
        assign mask_flat[k*DATA_W +: DATA_W] = mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode16 <= 1'b0;
        else if (wr_en && reg_addr == ADDR_W'(MODE_ADDR))
            mode16 <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(MODE_ADDR))
            reg_rdata = DATA_W'(mode16);
        for (int i = 0; i < N_BYTES; i++) begin
            if (reg_addr == ADDR_W'(code_addr(i, HALF)))
                reg_rdata = code_flat[i*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(mask_addr(i, HALF)))
                reg_rdata = mask_flat[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match #(
    parameter int DATA_W  = 8,
    parameter int N_BYTES = 8
) (
    input  logic [4*DATA_W-1:0]       id_word,
    input  logic [N_BYTES*DATA_W-1:0] code_flat,
    input  logic [N_BYTES*DATA_W-1:0] mask_flat,
    input  logic                      mode16,
    output logic [N_BYTES/2-1:0]      hit_vec
);
    localparam int ID_BYTES = 4;
    localparam int N_F16    = N_BYTES / 2;
    localparam int N_F32    = N_BYTES / 4;

    logic [N_BYTES-1:0] byte_ok;
    logic [N_F16-1:0]   hit16;
    logic [N_F32-1:0]   hit32;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_cmp
        localparam int SEL32 = k % ID_BYTES;
        localparam int SEL16 = k % 2;
        logic [DATA_W-1:0] id_b;
        logic [DATA_W-1:0] code_b;
        logic [DATA_W-1:0] mask_b;
        assign id_b   = mode16 ? id_word[(ID_BYTES-1-SEL16)*DATA_W +: DATA_W]
                               : id_word[(ID_BYTES-1-SEL32)*DATA_W +: DATA_W];
        assign code_b = code_flat[k*DATA_W +: DATA_W];
        assign mask_b = mask_flat[k*DATA_W +: DATA_W];
        assign byte_ok[k] = &((id_b ~^ code_b) | mask_b);
    end

    for (genvar j = 0; j < N_F16; j++) begin : g_f16
        assign hit16[j] = &byte_ok[2*j +: 2];
    end

    for (genvar j = 0; j < N_F32; j++) begin : g_f32
        assign hit32[j] = &byte_ok[4*j +: 4];
    end

    assign hit_vec = mode16 ? hit16 : N_F16'(hit32);

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] first_idx
);
    always_comb begin
        any_hit   = |hit_vec;
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_filt_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 8,
    parameter int N_BYTES = 8,
    localparam int ID_W   = 4 * DATA_W,
    localparam int N_FILT = N_BYTES / 2,
    localparam int IDX_W  = (N_FILT > 1) ? $clog2(N_FILT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_word,
    output logic              res_valid,
    output logic              accept,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [N_BYTES*DATA_W-1:0] code_flat;
    logic [N_BYTES*DATA_W-1:0] mask_flat;
    logic                      mode16;
    logic [N_FILT-1:0]         hit_vec;
    logic                      any_hit;
    logic [IDX_W-1:0]          first_idx;
    rep_state_e                state_q, state_d;

    can_filt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_BYTES(N_BYTES)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_open  (init_req & init_ack),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .code_flat(code_flat),
        .mask_flat(mask_flat),
        .mode16   (mode16)
    );

    can_filt_match #(
        .DATA_W (DATA_W),
        .N_BYTES(N_BYTES)
    ) match_i (
        .id_word  (id_word),
        .code_flat(code_flat),
        .mask_flat(mask_flat),
        .mode16   (mode16),
        .hit_vec  (hit_vec)
    );

    can_filt_prio #(
        .N    (N_FILT),
        .IDX_W(IDX_W)
    ) prio_i (
        .hit_vec  (hit_vec),
        .any_hit  (any_hit),
        .first_idx(first_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (id_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!id_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            hit_idx <= '0;
        end else if (id_valid) begin
            accept  <= any_hit;
            hit_idx <= first_idx;
        end else begin
            accept  <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int W_CFG = 64,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_req,
    input logic             init_ack,
    input logic             id_valid,
    input logic             res_valid,
    input logic             accept,
    input logic [IDX_W-1:0] hit_idx,
    input logic             mode16,
    input logic [W_CFG-1:0] code_flat,
    input logic [W_CFG-1:0] mask_flat
);
    // R7
    res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> res_valid);

    // R7
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !res_valid);

    // R6
    accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> res_valid);

    // R8
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_req && init_ack) |=> ($stable(code_flat) && $stable(mask_flat) && $stable(mode16)));

    // R4
    wide_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !mode16) |=> (!accept || hit_idx < IDX_W'(2)));

endmodule

bind can_acc_filter can_filt_chk #(
    .W_CFG(N_BYTES * DATA_W),
    .IDX_W(IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .init_ack (init_ack),
    .id_valid (id_valid),
    .res_valid(res_valid),
    .accept   (accept),
    .hit_idx  (hit_idx),
    .mode16   (mode16),
    .code_flat(code_flat),
    .mask_flat(mask_flat)
);

// File: tb/can_acc_filter_tb_top.sv
module can_acc_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        init_ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        id_valid = 1'b0;
    logic [31:0] id_word = '0;
    logic        res_valid;
    logic        accept;
    logic [1:0]  hit_idx;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_code[8];
    int m_mask[8];
    bit m_mode;
    bit e_valid;
    bit e_accept;
    int e_idx;

    always #2500ps clk = ~clk;

    can_acc_filter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .init_ack (init_ack),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .id_valid (id_valid),
        .id_word  (id_word),
        .res_valid(res_valid),
        .accept   (accept),
        .hit_idx  (hit_idx)
    );

    function automatic int model_read(input int a);
        if (a == 0) return int'(m_mode);
        if (a >= 16 && a < 20) return m_code[a-16];
        if (a >= 20 && a < 24) return m_mask[a-20];
        if (a >= 24 && a < 28) return m_code[a-24+4];
        if (a >= 28 && a < 32) return m_mask[a-28+4];
        return 0;
    endfunction

    task automatic model_eval(input logic [31:0] w, output bit hit, output int idx);
        int nb;
        int nf;
        hit = 1'b0;
        idx = 0;
        nb = m_mode ? 2 : 4;
        nf = m_mode ? 4 : 2;
        for (int f = nf - 1; f >= 0; f--) begin
            bit ok;
            ok = 1'b1;
            for (int i = 0; i < nb; i++) begin
                int idb;
                int b;
                b = f * nb + i;
                idb = int'(w[31-8*i -: 8]);
                if (((idb ^ m_code[b]) & ~m_mask[b] & 255) != 0) ok = 1'b0;
            end
            if (ok) begin
                hit = 1'b1;
                idx = f;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_code[i] = 0;
                m_mask[i] = 0;
            end
            m_mode = 1'b0;
            e_valid = 1'b0;
            e_accept = 1'b0;
            e_idx = 0;
        end else begin
            bit h;
            int x;
            e_valid = id_valid;
            if (id_valid) begin
                model_eval(id_word, h, x);
                e_accept = h;
                e_idx = x;
            end else begin
                e_accept = 1'b0;
            end
            if (reg_wr && init_req && init_ack) begin
                int a;
                a = int'(reg_addr);
                if (a == 0) m_mode = reg_wdata[0];
                else if (a >= 16 && a < 20) m_code[a-16] = int'(reg_wdata);
                else if (a >= 20 && a < 24) m_mask[a-20] = int'(reg_wdata);
                else if (a >= 24 && a < 28) m_code[a-24+4] = int'(reg_wdata);
                else if (a >= 28 && a < 32) m_mask[a-28+4] = int'(reg_wdata);
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_en && !done) begin
            check("R7", "res_valid", int'(res_valid), int'(e_valid));
            check("R6", "accept", int'(accept), int'(e_accept));
            check("R6", "hit_idx", int'(hit_idx), e_idx);
            check("R8", "reg_rdata", int'(reg_rdata), model_read(int'(reg_addr)));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, "readback", int'(reg_rdata), exp);
    endtask

    task automatic present(input string req, input logic [31:0] w, input int exp_acc, input int exp_idx);
        @(negedge clk);
        id_valid = 1'b1;
        id_word = w;
        @(negedge clk);
        id_valid = 1'b0;
        #1;
        check(req, "res_valid", int'(res_valid), 1);
        check(req, "accept", int'(accept), exp_acc);
        check(req, "hit_idx", int'(hit_idx), exp_idx);
    endtask

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        #1;
        // R1: reset state
        check("R1", "accept", int'(accept), 0);
        check("R1", "res_valid", int'(res_valid), 0);
        rd("R1", 5'h00, 0);
        for (int a = 16; a < 32; a++) rd("R1", 5'(a), 0);

        // R8: write outside initialization mode is dropped
        wr(5'h10, 8'hAA);
        rd("R8", 5'h10, 0);

        init_req = 1'b1;
        init_ack = 1'b1;
        wr(5'h10, 8'h12); wr(5'h11, 8'h34); wr(5'h12, 8'h56); wr(5'h13, 8'h78);
        wr(5'h18, 8'h9A); wr(5'h19, 8'hBC); wr(5'h1A, 8'hDE); wr(5'h1B, 8'hF0);
        rd("R8", 5'h12, 'h56);

        // R4: wide mode
        present("R4", 32'h12345678, 1, 0);
        present("R4", 32'h9ABCDEF0, 1, 1);
        // R3: one must-match bit differs
        present("R3", 32'h12345679, 0, 0);

        // R2: mask don't-care bits
        wr(5'h17, 8'h0F);
        present("R2", 32'h1234567F, 1, 0);
        present("R2", 32'h12345688, 0, 0);
        wr(5'h17, 8'h00);

        // R10: standard identifier low bits ignored
        wr(5'h15, 8'h07);
        present("R10", 32'h12335678, 1, 0);
        present("R10", 32'h12245678, 0, 0);
        wr(5'h15, 8'h00);

        // R6: lowest index wins, fully open filter 1
        wr(5'h1C, 8'hFF); wr(5'h1D, 8'hFF); wr(5'h1E, 8'hFF); wr(5'h1F, 8'hFF);
        present("R6", 32'h12345678, 1, 0);
        present("R6", 32'h00000000, 1, 1);
        wr(5'h1C, 8'h00); wr(5'h1D, 8'h00); wr(5'h1E, 8'h00); wr(5'h1F, 8'h00);

        // R5: narrow mode
        wr(5'h00, 8'h01);
        wr(5'h12, 8'hAB); wr(5'h13, 8'hCD);
        wr(5'h1A, 8'hAB); wr(5'h1B, 8'hCD);
        present("R5", 32'hABCD0000, 1, 1);
        present("R5", 32'h9ABCFFFF, 1, 2);
        present("R5", 32'h12340000, 1, 0);
        present("R5", 32'h11110000, 0, 0);

        // R9: unmapped address
        wr(5'h01, 8'h55);
        rd("R9", 5'h01, 0);
        rd("R9", 5'h00, 1);

        // R8: lock with only one status flag
        init_ack = 1'b0;
        wr(5'h00, 8'h00);
        rd("R8", 5'h00, 1);
        wr(5'h10, 8'hEE);
        present("R8", 32'h12340000, 1, 0);
        init_req = 1'b0;
        init_ack = 1'b1;
        wr(5'h12, 8'h00);
        rd("R8", 5'h12, 'hAB);

        // R7: back-to-back strobes then idle
        @(negedge clk);
        id_valid = 1'b1;
        id_word = 32'hABCD0000;
        @(negedge clk);
        id_word = 32'h9ABC0000;
        #1;
        check("R7", "first hit_idx", int'(hit_idx), 1);
        @(negedge clk);
        id_valid = 1'b0;
        #1;
        check("R7", "second hit_idx", int'(hit_idx), 2);
        @(negedge clk);
        #1;
        check("R7", "idle res_valid", int'(res_valid), 0);
        check("R7", "idle accept", int'(accept), 0);
        check("R7", "idle hit_idx held", int'(hit_idx), 2);

        // random phase, compared every clock by the model
        init_req = 1'b1;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            init_ack = ($urandom % 8) != 0;
            id_valid = $urandom % 2;
            if ($urandom % 2) begin
                int f;
                f = $urandom % 4;
                id_word = {8'(m_code[2*f]), 8'(m_code[2*f+1]), 16'($urandom)};
                if (!m_mode) id_word = {8'(m_code[(f%2)*4]), 8'(m_code[(f%2)*4+1]),
                                        8'(m_code[(f%2)*4+2]), 8'(m_code[(f%2)*4+3])};
                if ($urandom % 4 == 0) id_word[$urandom % 32] ^= 1'b1;
            end else begin
                id_word = $urandom;
            end
            reg_wr = ($urandom % 8) == 0;
            reg_addr = ($urandom % 8 == 0) ? 5'($urandom % 4) : 5'(16 + $urandom % 16);
            reg_wdata = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom);
        end
        @(negedge clk);
        reg_wr = 1'b0;
        id_valid = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule